// File: doc/BRIEF.md
# Register Valid-Flag Interlock Scoreboard

This block tracks, for every general register of an in-order five-stage pipeline, whether the register holds its final value or is still waiting for an in-flight result. Each register has one flag. A flag at 1 means the contents are current. A flag at 0 means an issued instruction will still overwrite the register. The operand-fetch stage presents the candidate instruction: two source IDs, one destination ID and an enable for each. The block replies with a combinational stall. When the instruction is allowed to leave operand fetch, the flag of its destination drops to 0. When the operand-store stage retires a result, it presents the register ID with a strobe, and that register's flag returns to 1 in the same cycle as the data write.

A later writer to a register that already has a pending write is held back. It waits until the earlier result retires, and only then claims the register. Because of this rule, a reader that waits on a flag is always released by the result that is youngest in program order, so write-after-write ordering is preserved without any extra tag storage. A result that retires in the same cycle as the lookup counts as already present. This saves one stall cycle per dependency. Register 0 can be configured to read as permanently valid.

Top module: `reg_interlock_sb`

## Requirements
- R1: After reset every register flag reads 1 on `reg_valid` (bit i is register i) and `of_stall` is 0.
- R2: When `of_valid` is 1, `of_stall` is 0 and `of_dst_en` is 1, the flag of `of_dst` reads 0 from the next clock edge on (register 0 excepted).
- R3: When `os_wb_en` is 1, the flag of `os_wb_id` reads 1 after the next clock edge, unless R8 applies.
- R4: `of_stall` is 1 in the same cycle whenever `of_valid` is 1 and an enabled source names a register whose flag is 0 and that register is not being retired this cycle.
- R5: `of_stall` is 1 whenever `of_valid` is 1, `of_dst_en` is 1, and the destination flag is 0 and not being retired this cycle. This is the write-after-write hold.
- R6: While an instruction is stalled, no flag is cleared. Only a retirement can change a flag in that cycle.
- R7: A source or destination whose ID equals `os_wb_id` while `os_wb_en` is 1 is treated as valid in that same cycle and causes no stall.
- R8: If an issuing instruction's destination equals the ID being retired in the same cycle, the flag reads 0 after the edge, because the clear takes priority over the set.
- R9: With `ZERO_REG_FIXED` set, register 0 is always valid. Its flag stays 1 and it never causes a stall, whether used as a source or as a destination.
- R10: A source or destination whose enable is 0 never causes a stall, and a destination whose enable is 0 is never cleared, whatever its ID.
- R11: When `of_valid` is 0, `of_stall` is 0 and no flag is cleared.
- R12: Several instructions waiting on the same pending register are all released by the single retirement of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| of_valid | input | 1 | An instruction occupies operand fetch |
| of_src_a | input | ID_W | First source register ID |
| of_src_a_en | input | 1 | First source is read |
| of_src_b | input | ID_W | Second source register ID |
| of_src_b_en | input | 1 | Second source is read |
| of_dst | input | ID_W | Destination register ID |
| of_dst_en | input | 1 | Instruction writes its destination |
| os_wb_en | input | 1 | Operand store retires a result this cycle |
| os_wb_id | input | ID_W | Register ID being retired |
| of_stall | output | 1 | Hold the instruction in operand fetch |
| reg_valid | output | NUM_REGS | Current flag of every register |

## Verification
A flag that is wrongly left at 1 shows up in the same cycle as a missing `of_stall` for a dependent reader or writer. A flag that is wrongly left at 0 shows up as a stall that never releases after the retirement. Both are also visible one edge after the offending issue or retirement on `reg_valid`. Priority errors (set winning over clear, or the bypass missing) change the first post-edge value of the affected bit. The bench therefore compares `of_stall` within every cycle and the whole flag vector after every edge against an arithmetic model.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    OPND_SRC_A = 2'd0,
    OPND_SRC_B = 2'd1,
    OPND_DST   = 2'd2
  } opnd_e;

  localparam int unsigned NUM_OPND = 3;

  // A flag counts as valid if stored valid or being retired this cycle.
  function automatic logic flag_seen(input logic stored, input logic retiring);
    return stored | retiring;
  endfunction

  // Next stored flag: a new claim overrides a retirement on the same register.
  function automatic logic flag_next(input logic cur, input logic claim, input logic retire);
    logic nxt;
    nxt = cur;
    if (retire) nxt = 1'b1;
    if (claim)  nxt = 1'b0;
    return nxt;
  endfunction

  // An operand blocks when it is used and its register is not yet seen valid.
  function automatic logic opnd_blocks(input logic used, input logic seen_valid);
    return used & ~seen_valid;
  endfunction

endpackage

// File: rtl/sb_id_decoder.sv
module sb_id_decoder #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned ID_W      = $clog2(NUM_REGS),
  parameter bit          SKIP_ZERO = 1'b1
) (
  input  logic                en,
  input  logic [ID_W-1:0]     id,
  output logic [NUM_REGS-1:0] hot
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
    if (SKIP_ZERO && i == 0) begin : g_fixed
      assign hot[i] = 1'b0;
    end else begin : g_cmp
      assign hot[i] = en && (id == ID_W'(i));
    end
  end

endmodule

// File: rtl/sb_flag_bank.sv
module sb_flag_bank #(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] claim_hot,
  input  logic [NUM_REGS-1:0] retire_hot,
  output logic [NUM_REGS-1:0] flags
);
  import sb_pkg::*;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b1;
      else        flag_q <= flag_next(flag_q, claim_hot[r], retire_hot[r]);
    end
    assign flags[r] = flag_q;
  end

endmodule

// File: rtl/sb_operand_probe.sv
module sb_operand_probe #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ID_W     = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] flags,
  input  logic [NUM_REGS-1:0] retire_hot,
  input  logic [ID_W-1:0]     id,
  input  logic                used,
  output logic                blocked
);
  import sb_pkg::*;

  logic seen_valid;

  always_comb begin
    seen_valid = flag_seen(flags[id], retire_hot[id]);
    blocked    = opnd_blocks(used, seen_valid);
  end

endmodule

// File: rtl/reg_interlock_sb.sv
module reg_interlock_sb #(
  parameter int unsigned NUM_REGS       = 32,
  parameter bit          ZERO_REG_FIXED = 1'b1,
  localparam int unsigned ID_W          = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                of_valid,
  input  logic [ID_W-1:0]     of_src_a,
  input  logic                of_src_a_en,
  input  logic [ID_W-1:0]     of_src_b,
  input  logic                of_src_b_en,
  input  logic [ID_W-1:0]     of_dst,
  input  logic                of_dst_en,
  input  logic                os_wb_en,
  input  logic [ID_W-1:0]     os_wb_id,
  output logic                of_stall,
  output logic [NUM_REGS-1:0] reg_valid
);
  import sb_pkg::*;

  // Named internal events, visible to the bound checker.
  logic                      issue_fire;
  logic                      wb_fire;
  logic [NUM_REGS-1:0]       claim_hot;
  logic [NUM_REGS-1:0]       retire_hot;
  logic [NUM_OPND-1:0]       opnd_blocked;
  logic [ID_W-1:0]           opnd_id  [NUM_OPND];
  logic [NUM_OPND-1:0]       opnd_use;

  assign opnd_id[OPND_SRC_A]  = of_src_a;
  assign opnd_id[OPND_SRC_B]  = of_src_b;
  assign opnd_id[OPND_DST]    = of_dst;
  assign opnd_use[OPND_SRC_A] = of_src_a_en;
  assign opnd_use[OPND_SRC_B] = of_src_b_en;
  assign opnd_use[OPND_DST]   = of_dst_en;

  assign wb_fire = os_wb_en;

  sb_id_decoder #(
    .NUM_REGS (NUM_REGS),
    .ID_W     (ID_W),
    .SKIP_ZERO(ZERO_REG_FIXED)
  ) u_retire_dec (
    .en (wb_fire),
    .id (os_wb_id),
    .hot(retire_hot)
  );

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_probe
    sb_operand_probe #(
      .NUM_REGS(NUM_REGS),
      .ID_W    (ID_W)
    ) u_probe (
      .flags     (reg_valid),
      .retire_hot(retire_hot),
      .id        (opnd_id[k]),
      .used      (opnd_use[k]),
      .blocked   (opnd_blocked[k])
    );
  end

  assign of_stall   = of_valid && (|opnd_blocked);
  assign issue_fire = of_valid && !of_stall && of_dst_en;

  sb_id_decoder #(
    .NUM_REGS (NUM_REGS),
    .ID_W     (ID_W),
    .SKIP_ZERO(ZERO_REG_FIXED)
  ) u_claim_dec (
    .en (issue_fire),
    .id (of_dst),
    .hot(claim_hot)
  );

  sb_flag_bank #(
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim_hot (claim_hot),
    .retire_hot(retire_hot),
    .flags     (reg_valid)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ID_W     = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                of_valid,
  input logic [ID_W-1:0]     of_src_a,
  input logic                of_src_a_en,
  input logic [ID_W-1:0]     of_dst,
  input logic                of_dst_en,
  input logic                os_wb_en,
  input logic [ID_W-1:0]     os_wb_id,
  input logic                of_stall,
  input logic [NUM_REGS-1:0] reg_valid,
  input logic                issue_fire,
  input logic [NUM_REGS-1:0] claim_hot
);

  assert_reset_all_valid_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (&reg_valid) && !of_stall);

  assert_issue_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && of_dst != '0) |=> !reg_valid[$past(of_dst)]);

  assert_retire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (os_wb_en && !(issue_fire && of_dst == os_wb_id)) |=> reg_valid[$past(os_wb_id)]);

  assert_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (of_valid && of_src_a_en && !reg_valid[of_src_a] && !(os_wb_en && os_wb_id == of_src_a))
      |-> of_stall);

  assert_waw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (of_valid && of_dst_en && !reg_valid[of_dst] && !(os_wb_en && os_wb_id == of_dst))
      |-> of_stall);

  assert_stall_no_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (of_stall && !os_wb_en) |=> reg_valid == $past(reg_valid));

  assert_claim_beats_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && of_dst != '0 && os_wb_en && os_wb_id == of_dst) |=> !reg_valid[$past(of_dst)]);

  assert_zero_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid[0] && !claim_hot[0]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !of_valid |-> !of_stall && $onehot0(claim_hot) && (claim_hot == '0));

endmodule

bind reg_interlock_sb sb_checker #(
  .NUM_REGS(NUM_REGS),
  .ID_W    (ID_W)
) u_sb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .of_valid   (of_valid),
  .of_src_a   (of_src_a),
  .of_src_a_en(of_src_a_en),
  .of_dst     (of_dst),
  .of_dst_en  (of_dst_en),
  .os_wb_en   (os_wb_en),
  .os_wb_id   (os_wb_id),
  .of_stall   (of_stall),
  .reg_valid  (reg_valid),
  .issue_fire (issue_fire),
  .claim_hot  (claim_hot)
);

// File: tb/tb_reg_interlock_sb.sv
`timescale 1ns/1ps
module tb_reg_interlock_sb;

  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       of_valid = 1'b0, of_src_a_en = 1'b0, of_src_b_en = 1'b0, of_dst_en = 1'b0;
  logic [4:0] of_src_a = '0, of_src_b = '0, of_dst = '0, os_wb_id = '0;
  logic       os_wb_en = 1'b0;
  logic       of_stall;
  logic [N-1:0] reg_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit model [N];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  reg_interlock_sb dut (
    .clk(clk), .rst_n(rst_n), .of_valid(of_valid),
    .of_src_a(of_src_a), .of_src_a_en(of_src_a_en),
    .of_src_b(of_src_b), .of_src_b_en(of_src_b_en),
    .of_dst(of_dst), .of_dst_en(of_dst_en),
    .os_wb_en(os_wb_en), .os_wb_id(os_wb_id),
    .of_stall(of_stall), .reg_valid(reg_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_vec();
    logic [31:0] v;
    for (int r = 0; r < N; r++) v[r] = model[r];
    return v;
  endfunction

  // One operand-fetch cycle: drive, check stall, clock, update model, check flags.
  task automatic cyc(input bit v, input logic [4:0] a, input bit ae, input logic [4:0] b, input bit be,
                     input logic [4:0] d, input bit de, input bit we, input logic [4:0] wi, input string tag);
    bit ready_a, ready_b, ready_d, exp_stall;
    of_valid = v; of_src_a = a; of_src_a_en = ae; of_src_b = b; of_src_b_en = be;
    of_dst = d; of_dst_en = de; os_wb_en = we; os_wb_id = wi;
    #1;
    ready_a = (a == 0) || model[a] || (we && wi == a);
    ready_b = (b == 0) || model[b] || (we && wi == b);
    ready_d = (d == 0) || model[d] || (we && wi == d);
    exp_stall = v && !((!ae || ready_a) && (!be || ready_b) && (!de || ready_d));
    chk(of_stall === exp_stall, {tag, " stall"}, {31'd0, of_stall}, {31'd0, exp_stall});
    @(posedge clk);
    if (we && wi != 0) model[wi] = 1'b1;
    if (v && !exp_stall && de && d != 0) model[d] = 1'b0;
    @(negedge clk);
    chk(reg_valid === model_vec(), {tag, " flags"}, reg_valid, model_vec());
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) model[r] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reg_valid === 32'hFFFF_FFFF, "R1 flags", reg_valid, 32'hFFFF_FFFF);
    chk(of_stall === 1'b0, "R1 stall", {31'd0, of_stall}, 32'd0);

    // Sweep every register: claim, read hold, WAW hold, retire.
    for (int r = 1; r < N; r++) begin
      cyc(1, 0, 0, 0, 0, 5'(r), 1, 0, 0, "R2 claim");
      chk(reg_valid[r] === 1'b0, "R2 bit", {31'd0, reg_valid[r]}, 32'd0);
      cyc(1, 5'(r), 1, 0, 0, 0, 0, 0, 0, "R4 src_a hold");
      cyc(1, 0, 0, 5'(r), 1, 0, 0, 0, 0, "R4 src_b hold");
      cyc(1, 0, 0, 0, 0, 5'(r), 1, 0, 0, "R5 waw hold");
      chk(reg_valid[r] === 1'b0, "R6 no claim while stalled", {31'd0, reg_valid[r]}, 32'd0);
      cyc(1, 5'(r), 0, 5'(r), 0, 5'(r), 0, 0, 0, "R10 unused ids");
      cyc(0, 5'(r), 1, 5'(r), 1, 5'(r), 1, 0, 0, "R11 idle");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'(r), "R3 retire");
      chk(reg_valid[r] === 1'b1, "R3 bit", {31'd0, reg_valid[r]}, 32'd1);
    end

    // R12: two readers wait on r5, bypassed in the retire cycle (R7).
    cyc(1, 0, 0, 0, 0, 5, 1, 0, 0, "R12 claim");
    cyc(1, 5, 1, 5, 1, 9, 1, 0, 0, "R12 both hold");
    chk(of_stall === 1'b1, "R12 stall seen", {31'd0, of_stall}, 32'd1);
    cyc(1, 5, 1, 5, 1, 9, 1, 1, 5, "R7 bypass release");
    cyc(1, 5, 1, 0, 0, 10, 1, 0, 0, "R12 second reader");
    chk(reg_valid[10:9] === 2'b00, "R12 both issued", {30'd0, reg_valid[10:9]}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 9, "R3 retire 9");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 10, "R3 retire 10");

    // R8: claim wins over same-cycle retirement.
    cyc(1, 0, 0, 0, 0, 7, 1, 0, 0, "R8 first claim");
    cyc(1, 0, 0, 0, 0, 7, 1, 1, 7, "R8 claim+retire");
    chk(reg_valid[7] === 1'b0, "R8 bit", {31'd0, reg_valid[7]}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7, "R3 retire 7");

    // R9: register 0 never pending.
    cyc(1, 0, 1, 0, 1, 0, 1, 0, 0, "R9 zero use");
    cyc(1, 0, 1, 0, 0, 0, 1, 1, 0, "R9 zero retire");
    chk(reg_valid[0] === 1'b1, "R9 bit", {31'd0, reg_valid[0]}, 32'd1);

    // Random mix against the model.
    for (int i = 0; i < 3000; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      cyc(seed[0], seed[5:1], seed[6], seed[11:7], seed[12], seed[17:13], seed[18],
          seed[19] | seed[20], seed[25:21], "R4 R5 R7 R8 mix");
    end
    idle("R11 tail");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule